// File: doc/BRIEF.md
# Multiplexed Code-Fetch Bus Interface

This block sits between a core's instruction-fetch port and program memory. The core supplies a 16-bit byte address and a one-cycle request strobe. The block then reads one byte from one of two places. The first is a small internal code store, reached through a synchronous read port. The second is an external memory on a shared 8-bit bus. On that bus the low address byte and the returned data use the same pins at different times, and a separate 8-bit port carries the upper address byte. The byte goes back to the core with a single-cycle valid pulse.

An external fetch runs through fixed phases. First the full address is driven while the latch strobe is high, for a parameterized number of cycles. The latch strobe then drops while the address is still held for one cycle. The low port is released for one turnaround cycle. After that, the active-low code-read strobe is asserted for a parameterized number of cycles. The byte on the low port is captured at the clock edge that ends the last strobe cycle.

The select input controls routing. When it is low, every fetch goes out to the bus. When it is high, addresses below 2^INT_AW (0x1000 by default) are read from the internal store, and all higher addresses go out to the bus. The block handles one fetch at a time.

Top module: `codefetch_mux_bus`

## Requirements
- R1: After reset: fetch_busy=0, fetch_valid=0, addr_latch=0, code_rd_n=1, bus_lo_oe=0, int_rd_en=0, bus_hi=0xFF.
- R2: When use_internal=1 and fetch_addr < 0x1000 at acceptance, int_rd_en is high for exactly the first cycle after the accepting edge, with int_rd_addr = fetch_addr[11:0]. No bus strobe is driven. fetch_valid is high in the third cycle, and fetch_data carries the byte the store returned.
- R3: When use_internal=0, or when fetch_addr >= 0x1000, the fetch goes out on the external bus. The first cycle after acceptance has addr_latch=1 and int_rd_en=0.
- R4: addr_latch is high for exactly ALE_CYC consecutive cycles. During those cycles bus_lo_oe=1, bus_lo_out=fetch_addr[7:0] and bus_hi=fetch_addr[15:8].
- R5: In the cycle after addr_latch falls, bus_lo_oe stays 1 and the address stays on bus_lo_out. The next cycle has bus_lo_oe=0 and code_rd_n=1.
- R6: code_rd_n is low for exactly PS_CYC consecutive cycles. bus_lo_oe is never 1 while code_rd_n is 0.
- R7: fetch_data takes the value of bus_lo_in from the last cycle in which code_rd_n is low. fetch_valid goes high in the cycle in which code_rd_n returns to 1, which is cycle ALE_CYC+PS_CYC+3 after acceptance.
- R8: bus_hi holds fetch_addr[15:8] in every cycle of an external fetch and reads 0xFF when no external fetch is in progress.
- R9: fetch_busy is high from the cycle after acceptance until fetch_valid rises, and it is low in the valid cycle. A fetch_req that arrives while busy is ignored: it does not change the returned byte and does not start another fetch.
- R10: fetch_valid lasts exactly one cycle, and fetch_data keeps its value after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, sampled when idle |
| fetch_addr | input | 16 | Fetch byte address |
| use_internal | input | 1 | 1: low addresses served internally; 0: all fetches external |
| fetch_busy | output | 1 | A fetch is in progress |
| fetch_valid | output | 1 | One-cycle pulse, fetch_data valid |
| fetch_data | output | 8 | Fetched byte |
| int_rd_en | output | 1 | Internal store read enable |
| int_rd_addr | output | INT_AW | Internal store read address |
| int_rd_data | input | 8 | Internal store data, one cycle after int_rd_en |
| addr_latch | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | External code-read strobe, active low |
| bus_lo_out | output | 8 | Low port value (address low byte) |
| bus_lo_oe | output | 1 | Low port drive enable |
| bus_lo_in | input | 8 | Low port sampled value (data) |
| bus_hi | output | 8 | High address byte port |

## Verification
Some properties are checked by assertions on every cycle:
- the low port is never driven while the read strobe is asserted;
- the port is released in the cycle before the strobe;
- the address is still driven in the cycle after the latch strobe falls;
- valid coincides with the rising edge of the strobe;
- the high byte does not change during the strobe;
- valid and busy are never high together;
- an internal read never overlaps a bus strobe.

Other properties only the bench's scenarios can show: the exact phase lengths, the routing decision on each side of 0x1000 for both select settings, the captured byte against the address decoded by an external latch, and whether a request made while busy is ignored. The bench sweeps all 256 upper address bytes under both select settings.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    // Width of the phase counter; ALE_CYC and PS_CYC must not exceed 2**CNT_W.
    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_IREQ  = 3'd1,  // internal read issued
        PH_ICAP  = 3'd2,  // internal data returned
        PH_ALE   = 3'd3,  // address driven, latch strobe high
        PH_AHOLD = 3'd4,  // latch strobe low, address still driven
        PH_TURN  = 3'd5,  // low port released, strobe not yet asserted
        PH_STRB  = 3'd6   // code-read strobe asserted
    } phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [15:0]      addr;
        logic [7:0]       data;
        logic             valid;
    } seq_state_t;

endpackage

// File: rtl/cfb_route.sv
module cfb_route #(
    parameter int INT_AW = 12
) (
    input  logic [15:0] addr,
    input  logic        use_internal,
    output logic        go_int
);
    localparam int HI_W = 16 - INT_AW;

    generate
        if (HI_W <= 0) begin : g_full
            assign go_int = use_internal;
        end else begin : g_window
            logic [HI_W-1:0] upper;
            assign upper  = addr[15:INT_AW];
            assign go_int = use_internal && (upper == '0);
        end
    endgenerate

endmodule

// File: rtl/cfb_seq.sv
module cfb_seq
    import cfb_pkg::*;
#(
    parameter int ALE_CYC = 2,
    parameter int PS_CYC  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [15:0] addr,
    input  logic        go_int,
    input  logic [7:0]  lo_in,
    input  logic [7:0]  int_data,
    output phase_e      ph,
    output logic [15:0] addr_q,
    output logic [7:0]  data_q,
    output logic        valid_q
);
    localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYC - 1);
    localparam logic [CNT_W-1:0] PS_LAST  = CNT_W'(PS_CYC - 1);

    seq_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    st_d.addr = addr;
                    st_d.cnt  = '0;
                    st_d.ph   = go_int ? PH_IREQ : PH_ALE;
                end
            end
            PH_IREQ: st_d.ph = PH_ICAP;
            PH_ICAP: begin
                st_d.data  = int_data;
                st_d.valid = 1'b1;
                st_d.ph    = PH_IDLE;
            end
            PH_ALE: begin
                if (st_q.cnt == ALE_LAST) begin
                    st_d.cnt = '0;
                    st_d.ph  = PH_AHOLD;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_AHOLD: st_d.ph = PH_TURN;
            PH_TURN: begin
                st_d.cnt = '0;
                st_d.ph  = PH_STRB;
            end
            PH_STRB: begin
                if (st_q.cnt == PS_LAST) begin
                    st_d.data  = lo_in;
                    st_d.valid = 1'b1;
                    st_d.ph    = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, data: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ph      = st_q.ph;
    assign addr_q  = st_q.addr;
    assign data_q  = st_q.data;
    assign valid_q = st_q.valid;

endmodule

// File: rtl/cfb_pins.sv
module cfb_pins
    import cfb_pkg::*;
#(
    parameter int         INT_AW  = 12,
    parameter logic [7:0] IDLE_HI = 8'hFF
) (
    input  phase_e            ph,
    input  logic [15:0]       addr_q,
    output logic              addr_latch,
    output logic              code_rd_n,
    output logic              bus_lo_oe,
    output logic [7:0]        bus_lo_out,
    output logic [7:0]        bus_hi,
    output logic              int_rd_en,
    output logic [INT_AW-1:0] int_rd_addr
);
    logic ext_active;

    always_comb begin
        ext_active  = (ph == PH_ALE) || (ph == PH_AHOLD) ||
                      (ph == PH_TURN) || (ph == PH_STRB);
        addr_latch  = (ph == PH_ALE);
        code_rd_n   = (ph != PH_STRB);
        bus_lo_oe   = (ph == PH_ALE) || (ph == PH_AHOLD);
        bus_lo_out  = bus_lo_oe ? addr_q[7:0] : 8'hFF;
        bus_hi      = ext_active ? addr_q[15:8] : IDLE_HI;
        int_rd_en   = (ph == PH_IREQ);
        int_rd_addr = addr_q[INT_AW-1:0];
    end

endmodule

// File: rtl/codefetch_mux_bus.sv
module codefetch_mux_bus
    import cfb_pkg::*;
#(
    parameter int         ALE_CYC = 2,
    parameter int         PS_CYC  = 3,
    parameter int         INT_AW  = 12,
    parameter logic [7:0] IDLE_HI = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [15:0]       fetch_addr,
    input  logic              use_internal,
    output logic              fetch_busy,
    output logic              fetch_valid,
    output logic [7:0]        fetch_data,
    output logic              int_rd_en,
    output logic [INT_AW-1:0] int_rd_addr,
    input  logic [7:0]        int_rd_data,
    output logic              addr_latch,
    output logic              code_rd_n,
    output logic [7:0]        bus_lo_out,
    output logic              bus_lo_oe,
    input  logic [7:0]        bus_lo_in,
    output logic [7:0]        bus_hi
);
    logic        go_int;
    phase_e      ph;
    logic [15:0] addr_q;

    cfb_route #(.INT_AW(INT_AW)) u_route (
        .addr         (fetch_addr),
        .use_internal (use_internal),
        .go_int       (go_int)
    );

    cfb_seq #(.ALE_CYC(ALE_CYC), .PS_CYC(PS_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (fetch_req),
        .addr     (fetch_addr),
        .go_int   (go_int),
        .lo_in    (bus_lo_in),
        .int_data (int_rd_data),
        .ph       (ph),
        .addr_q   (addr_q),
        .data_q   (fetch_data),
        .valid_q  (fetch_valid)
    );

    cfb_pins #(.INT_AW(INT_AW), .IDLE_HI(IDLE_HI)) u_pins (
        .ph          (ph),
        .addr_q      (addr_q),
        .addr_latch  (addr_latch),
        .code_rd_n   (code_rd_n),
        .bus_lo_oe   (bus_lo_oe),
        .bus_lo_out  (bus_lo_out),
        .bus_hi      (bus_hi),
        .int_rd_en   (int_rd_en),
        .int_rd_addr (int_rd_addr)
    );

    assign fetch_busy = (ph != PH_IDLE);

endmodule

// File: rtl/cfb_chk.sv
module cfb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_valid,
    input logic       fetch_busy,
    input logic       int_rd_en,
    input logic       addr_latch,
    input logic       code_rd_n,
    input logic       bus_lo_oe,
    input logic [7:0] bus_hi
);
    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_rd_n |-> !bus_lo_oe);

    // R5
    turn_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(code_rd_n) |-> !$past(bus_lo_oe));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_latch) |-> bus_lo_oe);

    // R4
    latch_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |-> (bus_lo_oe && code_rd_n));

    // R7
    strobe_end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_rd_n) |-> fetch_valid);

    // R8
    hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_rd_n && !$past(code_rd_n)) |-> $stable(bus_hi));

    // R9
    valid_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !fetch_busy);

    // R10
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid);

    // R2
    internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd_en |-> (code_rd_n && !addr_latch && !bus_lo_oe));

endmodule

bind codefetch_mux_bus cfb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_busy  (fetch_busy),
    .int_rd_en   (int_rd_en),
    .addr_latch  (addr_latch),
    .code_rd_n   (code_rd_n),
    .bus_lo_oe   (bus_lo_oe),
    .bus_hi      (bus_hi)
);

// File: tb/sim_codefetch_mux_bus.sv
module sim_codefetch_mux_bus;
    localparam int CLK_PER = 10;
    localparam int A  = 2;
    localparam int P  = 3;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [15:0]   fetch_addr = '0;
    logic          use_internal = 1'b0;
    logic          fetch_busy, fetch_valid;
    logic [7:0]    fetch_data;
    logic          int_rd_en;
    logic [AW-1:0] int_rd_addr;
    logic [7:0]    int_rd_data = '0;
    logic          addr_latch, code_rd_n, bus_lo_oe;
    logic [7:0]    bus_lo_out, bus_hi, bus_lo_in;
    logic [15:0]   latched = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    codefetch_mux_bus #(.ALE_CYC(A), .PS_CYC(P), .INT_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .use_internal(use_internal), .fetch_busy(fetch_busy), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .int_rd_en(int_rd_en), .int_rd_addr(int_rd_addr),
        .int_rd_data(int_rd_data), .addr_latch(addr_latch), .code_rd_n(code_rd_n),
        .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_lo_in(bus_lo_in), .bus_hi(bus_hi)
    );

    function automatic logic [7:0] ext_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] int_byte(input logic [AW-1:0] a);
        return a[7:0] + {4'h0, a[11:8]} + 8'h3C;
    endfunction

    // external latch and memory model
    always @(negedge addr_latch) latched = {bus_hi, bus_lo_out};
    assign bus_lo_in = code_rd_n ? 8'h00 : ext_byte(latched);

    // internal store model: one-cycle synchronous read
    always @(posedge clk) if (int_rd_en) int_rd_data <= int_byte(int_rd_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic run_fetch(input logic [15:0] a, input logic ien, input logic inject);
        logic ext;
        int lat, n_ale, n_ps, n_cont, n_hibad, n_busy, vcyc;
        logic [7:0] vdata, exp_d;
        ext   = !ien || (a >= 16'h1000);
        lat   = ext ? (A + P + 3) : 3;
        exp_d = ext ? ext_byte(a) : int_byte(a[AW-1:0]);
        n_ale = 0; n_ps = 0; n_cont = 0; n_hibad = 0; n_busy = 0; vcyc = 0; vdata = '0;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; use_internal = ien;
        for (int c = 1; c <= lat + 1; c++) begin
            @(negedge clk);
            if (c == 1) fetch_req = 1'b0;
            if (inject && c == 2) begin fetch_req = 1'b1; fetch_addr = ~a; end
            if (inject && c == 3) fetch_req = 1'b0;
            if (c == 1) begin
                chk(ext ? "R3 route latch" : "R2 route latch", 32'(addr_latch), 32'(ext));
                chk("R2 int_rd_en first cycle", 32'(int_rd_en), 32'(!ext));
                if (ext) begin
                    chk("R4 low address", 32'(bus_lo_out), 32'(a[7:0]));
                    chk("R4 low drive", 32'(bus_lo_oe), 32'd1);
                end else begin
                    chk("R2 int_rd_addr", 32'(int_rd_addr), 32'(a[AW-1:0]));
                end
            end
            if (!ext && c > 1) chk("R2 single read", 32'(int_rd_en), 32'd0);
            if (ext && c == A + 1) begin
                chk("R5 hold drive", 32'(bus_lo_oe), 32'd1);
                chk("R5 hold addr", 32'(bus_lo_out), 32'(a[7:0]));
            end
            if (ext && c == A + 2) begin
                chk("R5 turn released", 32'(bus_lo_oe), 32'd0);
                chk("R5 turn strobe", 32'(code_rd_n), 32'd1);
            end
            if (addr_latch) n_ale++;
            if (!code_rd_n) n_ps++;
            if (!code_rd_n && bus_lo_oe) n_cont++;
            if (ext && c < lat && bus_hi !== a[15:8]) n_hibad++;
            if (c < lat && fetch_busy) n_busy++;
            if (fetch_valid && vcyc == 0) begin vcyc = c; vdata = fetch_data; end
            if (c == lat) begin
                chk("R9 busy low at valid", 32'(fetch_busy), 32'd0);
                chk("R8 idle high byte", 32'(bus_hi), 32'hFF);
            end
            if (c == lat + 1) begin
                chk("R10 valid one cycle", 32'(fetch_valid), 32'd0);
                chk("R10 data held", 32'(fetch_data), 32'(exp_d));
                chk("R9 no second fetch", 32'(fetch_busy | addr_latch | int_rd_en), 32'd0);
            end
        end
        chk("R4 latch length", 32'(n_ale), ext ? 32'(A) : 32'd0);
        chk("R6 strobe length", 32'(n_ps), ext ? 32'(P) : 32'd0);
        chk("R6 no contention", 32'(n_cont), 32'd0);
        chk("R8 high byte held", 32'(n_hibad), 32'd0);
        chk("R9 busy span", 32'(n_busy), 32'(lat - 1));
        chk("R7 valid cycle", 32'(vcyc), 32'(lat));
        chk(ext ? "R7 external byte" : "R2 internal byte", 32'(vdata), 32'(exp_d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", 32'(fetch_busy), 32'd0);
        chk("R1 valid", 32'(fetch_valid), 32'd0);
        chk("R1 latch", 32'(addr_latch), 32'd0);
        chk("R1 strobe", 32'(code_rd_n), 32'd1);
        chk("R1 drive", 32'(bus_lo_oe), 32'd0);
        chk("R1 int read", 32'(int_rd_en), 32'd0);
        chk("R1 high byte", 32'(bus_hi), 32'hFF);

        // boundaries of the internal window
        run_fetch(16'h0000, 1'b1, 1'b0);
        run_fetch(16'h0FFF, 1'b1, 1'b0);
        run_fetch(16'h1000, 1'b1, 1'b0);
        run_fetch(16'hFFFF, 1'b1, 1'b0);
        run_fetch(16'h0FFF, 1'b0, 1'b0);
        run_fetch(16'h0000, 1'b0, 1'b0);
        // requests made while busy must be ignored
        run_fetch(16'h0ABC, 1'b1, 1'b1);
        run_fetch(16'h4321, 1'b1, 1'b1);
        run_fetch(16'h0123, 1'b0, 1'b1);

        // sweep every high byte, both selector settings
        for (int i = 0; i < 256; i++) begin
            for (int s = 0; s < 2; s++) begin
                run_fetch({i[7:0], i[7:0] ^ 8'h3C}, s[0], 1'b0);
            end
        end
        summary();
        $finish;
    end

endmodule